// File: doc/BRIEF.md
# Fully Associative Write-Back Cache

This block is the tag store, line store and controller of a small fully associative cache. Any memory block may sit in any line. The cache splits each access address into a tag and an offset within the block. It compares that tag against the stored tags of every valid line at the same time. A hit returns the selected word one cycle after the request is accepted. A miss picks a victim line. If the victim holds modified data, the cache first writes the whole line back through a line-wide memory port. It then reads the requested block through the same port, installs it and answers the request.

Victim choice works in two steps. A line that is not yet valid is always used before any valid line is evicted. Once every line is valid, a parameter selects the policy. In FIFO mode the victim is the line that was filled longest ago. In random mode the victim comes from a linear feedback shift register that restarts from the same seed at every reset, so runs can be reproduced. Writes hit or allocate, and written lines are held dirty until they are evicted.

Top module: `fa_cache`

## Requirements
- R1: After reset every line is invalid and clean, `ready_o` is 1, and `resp_valid_o` and `mem_req_o` are 0.
- R2: With the default 32-bit address and 32-byte line, the tag is `addr_i[31:5]`, the word select is `addr_i[4:2]`, and `addr_i[1:0]` is ignored. A line matches only when it is valid and its stored tag equals the tag. At most one line matches at a time.
- R3: A read hit accepted at a clock edge (`req_i` high while `ready_o` is 1) raises `resp_valid_o` for one cycle after that edge. It also sets `hit_o`=1, puts the matching line on `line_o` and the selected word on `rdata_o`. A hit makes no memory request.
- R4: A write hit replaces the selected word, marks the line dirty and returns the written value on `rdata_o`. Later reads of that word return the new value.
- R5: A miss reads the block with `mem_we_o`=0 and `mem_addr_o` equal to the tag. In the cycle after `mem_ack_i`, the block raises `resp_valid_o` with `hit_o`=0, `line_o` set to the filled line, and `rdata_o` set to the requested word. On a write miss, the written word is merged into the fetched line and returned.
- R6: While any line is invalid, a miss fills the lowest-numbered invalid line.
- R7: A dirty victim is written back (`mem_we_o`=1, `mem_addr_o` equal to the old tag, `mem_wdata_o` equal to the full line) before the fill read is issued. A clean victim causes no write.
- R8: With `REPL`=`REPL_FIFO` and all lines valid, the victim is the line whose fill is oldest. Lines rank by their last fill, and hits do not change that order.
- R9: With `REPL`=`REPL_RANDOM` and all lines valid, the victim is the low `log2(NUM_LINES)` bits of a 16-bit register. The register resets to `LFSR_SEED` (default 16'hACE1). On each eviction of a valid line it shifts left by one, and bit 0 takes the XOR of bits 15, 13, 12 and 10. Hits and fills of invalid lines leave the register unchanged.
- R10: `mem_req_o` stays high until `mem_ack_i`. `ready_o` is 0 from the acceptance of a miss until its response, and a response only appears when `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is 1 |
| we_i | input | 1 | 1 for a word write, 0 for a read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write word |
| ready_o | output | 1 | Controller idle and able to accept |
| resp_valid_o | output | 1 | One-cycle response strobe |
| hit_o | output | 1 | Response was a hit |
| line_o | output | IDX_W | Line that served the access |
| rdata_o | output | DATA_W | Word read, or word written |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write-back, 0 for fill read |
| mem_addr_o | output | TAG_W | Block address (tag) |
| mem_wdata_o | output | LINE_W | Line being written back |
| mem_ack_i | input | 1 | Memory completes the request |
| mem_rdata_i | input | LINE_W | Block returned on a fill, valid with the acknowledge |

## Verification
A cold-start sweep over eight blocks checks invalid-first placement, with each miss landing on line 0 to 7 in order. A full re-read of every word of every block then separates parallel tag matching and word selection from the miss path. A byte-offset variant confirms that the low address bits are ignored. Runs of new blocks in FIFO mode, interleaved with hits, show that only fills set the eviction order. Writes placed on chosen lines show that write-back happens only for dirty victims and carries the modified word. A second instance in random mode is checked against the stated shift-register sequence, with a hit after every miss to show that hits do not advance it.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic {
    REPL_FIFO   = 1'b0,
    REPL_RANDOM = 1'b1
  } repl_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int NUM_LINES = 8,
  parameter int TAG_W     = 27,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_LINES-1:0]            valid_i,
  input  logic [NUM_LINES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]                tag_i,
  output logic [NUM_LINES-1:0]            match_o,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                idx_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |match_o;

  // one-hot to index by OR; correct only while matches stay unique
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel
  import fa_cache_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter int          IDX_W     = 3,
  parameter repl_e       REPL      = REPL_FIFO,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] valid_i,
  input  logic                 miss_i,
  output logic [IDX_W-1:0]     victim_o
);
  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] policy_idx;
  logic             evict;

  // lowest-numbered invalid line wins
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign evict = miss_i && !have_free;

  if (REPL == REPL_RANDOM) begin : g_rand
    logic [15:0] lfsr_q;
    logic        fb;
    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lfsr_q <= LFSR_SEED;
      else if (evict) lfsr_q <= {lfsr_q[14:0], fb};
    end
    assign policy_idx = lfsr_q[IDX_W-1:0];
  end else begin : g_fifo
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ptr_q <= '0;
      else if (evict) ptr_q <= ptr_q + 1'b1;
    end
    assign policy_idx = ptr_q;
  end

  assign victim_o = have_free ? free_idx : policy_idx;
endmodule

// File: rtl/fa_cache.sv
module fa_cache
  import fa_cache_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          LINE_BYTES = 32,
  parameter int          NUM_LINES  = 8,
  parameter repl_e       REPL       = REPL_FIFO,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int WORD_W = OFF_W - BYTE_W,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int IDX_W  = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  line_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [TAG_W-1:0]  mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  state_e                          state_q;
  logic [NUM_LINES-1:0]            valid_q;
  logic [NUM_LINES-1:0]            dirty_q;
  logic [NUM_LINES-1:0][TAG_W-1:0] tags_q;
  logic [LINE_W-1:0]               data_q [NUM_LINES];

  logic [TAG_W-1:0]  req_tag_q;
  logic [WORD_W-1:0] req_word_q;
  logic              req_we_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [IDX_W-1:0]  victim_q;

  logic              resp_valid_q;
  logic              hit_q;
  logic [IDX_W-1:0]  line_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]     tag_in;
  logic [WORD_W-1:0]    word_in;
  logic                 accept;
  logic                 fill_done;
  logic [NUM_LINES-1:0] match_vec;
  logic                 lookup_hit;
  logic [IDX_W-1:0]     hit_idx;
  logic [IDX_W-1:0]     victim;
  logic [LINE_W-1:0]    hit_line;
  logic [DATA_W-1:0]    hit_word;
  logic [LINE_W-1:0]    fill_line;
  logic                 unused_byte_sel;

  assign tag_in          = addr_i[ADDR_W-1:OFF_W];
  assign word_in         = addr_i[OFF_W-1:BYTE_W];
  assign unused_byte_sel = ^addr_i[BYTE_W-1:0];
  assign accept          = req_i && (state_q == ST_IDLE);
  assign fill_done       = (state_q == ST_FILL) && mem_ack_i;

  fa_tag_match #(
    .NUM_LINES(NUM_LINES),
    .TAG_W    (TAG_W),
    .IDX_W    (IDX_W)
  ) u_match (
    .valid_i(valid_q),
    .tags_i (tags_q),
    .tag_i  (tag_in),
    .match_o(match_vec),
    .hit_o  (lookup_hit),
    .idx_o  (hit_idx)
  );

  fa_victim_sel #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W),
    .REPL     (REPL),
    .LFSR_SEED(LFSR_SEED)
  ) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .miss_i  (accept && !lookup_hit),
    .victim_o(victim)
  );

  assign hit_line = data_q[hit_idx];
  assign hit_word = hit_line[word_in*DATA_W +: DATA_W];

  // write miss: merge the store into the fetched block
  always_comb begin
    fill_line = mem_rdata_i;
    if (req_we_q) fill_line[req_word_q*DATA_W +: DATA_W] = req_wdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      valid_q      <= '0;
      dirty_q      <= '0;
      tags_q       <= '0;
      req_tag_q    <= '0;
      req_word_q   <= '0;
      req_we_q     <= 1'b0;
      req_wdata_q  <= '0;
      victim_q     <= '0;
      resp_valid_q <= 1'b0;
      hit_q        <= 1'b0;
      line_q       <= '0;
      rdata_q      <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && lookup_hit) begin
            resp_valid_q <= 1'b1;
            hit_q        <= 1'b1;
            line_q       <= hit_idx;
            rdata_q      <= we_i ? wdata_i : hit_word;
            if (we_i) dirty_q[hit_idx] <= 1'b1;
          end else if (accept) begin
            req_tag_q   <= tag_in;
            req_word_q  <= word_in;
            req_we_q    <= we_i;
            req_wdata_q <= wdata_i;
            victim_q    <= victim;
            state_q     <= (valid_q[victim] && dirty_q[victim]) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ack_i) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            tags_q[victim_q]  <= req_tag_q;
            valid_q[victim_q] <= 1'b1;
            dirty_q[victim_q] <= req_we_q;
            resp_valid_q      <= 1'b1;
            hit_q             <= 1'b0;
            line_q            <= victim_q;
            rdata_q           <= fill_line[req_word_q*DATA_W +: DATA_W];
            state_q           <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage carries no reset; valid bits gate its use
  always_ff @(posedge clk_i) begin
    if (accept && lookup_hit && we_i) data_q[hit_idx][word_in*DATA_W +: DATA_W] <= wdata_i;
    if (fill_done) data_q[victim_q] <= fill_line;
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign resp_valid_o = resp_valid_q;
  assign hit_o        = hit_q;
  assign line_o       = line_q;
  assign rdata_o      = rdata_q;
  assign mem_req_o    = (state_q != ST_IDLE);
  assign mem_we_o     = (state_q == ST_WBACK);
  assign mem_addr_o   = (state_q == ST_WBACK) ? tags_q[victim_q] : req_tag_q;
  assign mem_wdata_o  = data_q[victim_q];
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 ready_o,
  input logic                 resp_valid_o,
  input logic                 hit_o,
  input logic [IDX_W-1:0]     line_o,
  input logic                 mem_req_o,
  input logic                 mem_we_o,
  input logic                 mem_ack_i,
  input logic [NUM_LINES-1:0] match_vec,
  input logic                 lookup_hit,
  input logic [NUM_LINES-1:0] valid_q,
  input logic [IDX_W-1:0]     victim_q
);
  p_single_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  p_hit_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && lookup_hit |=> resp_valid_o && hit_o && !mem_req_o);

  p_miss_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && !lookup_hit |=> !resp_valid_o && mem_req_o && !ready_o);

  p_fill_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=> resp_valid_o && !hit_o && valid_q[line_o]);

  p_free_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && !lookup_hit && !(&valid_q) |=> !valid_q[victim_q]);

  p_wb_then_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> mem_req_o && !mem_we_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o));

  p_resp_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ready_o);
endmodule

bind fa_cache fa_cache_chk #(
  .NUM_LINES(NUM_LINES),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .resp_valid_o(resp_valid_o),
  .hit_o       (hit_o),
  .line_o      (line_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .match_vec   (match_vec),
  .lookup_hit  (lookup_hit),
  .valid_q     (valid_q),
  .victim_q    (victim_q)
);

// File: tb/tb_fa_cache.sv
module tb_mem (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         we,
  input  logic [26:0]  addr,
  input  logic [255:0] wdata,
  output logic         ack,
  output logic [255:0] rdata,
  output int           wb_cnt,
  output logic [26:0]  wb_addr,
  output logic [255:0] wb_data
);
  logic [255:0] store [logic [26:0]];
  int cnt;

  function automatic logic [255:0] line_pat(input logic [26:0] b);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = (32'(b) * 8 + 32'(w)) * 32'h9E3779B1 + 32'h1234;
    return l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; wb_cnt <= 0; rdata <= '0; wb_addr <= '0; wb_data <= '0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (cnt == 2) begin
          ack <= 1'b1;
          cnt <= 0;
          if (we) begin
            store[addr] = wdata;
            wb_cnt  <= wb_cnt + 1;
            wb_addr <= addr;
            wb_data <= wdata;
          end else begin
            rdata <= store.exists(addr) ? store[addr] : line_pat(addr);
          end
        end else cnt <= cnt + 1;
      end
    end
  end
endmodule

module tb_fa_cache;
  import fa_cache_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_f = 0, we_f = 0, req_r = 0, we_r = 0;
  logic [31:0] addr_f = 0, wd_f = 0, addr_r = 0, wd_r = 0;
  logic        rdy_f, rv_f, hit_f, rdy_r, rv_r, hit_r;
  logic [2:0]  line_f, line_r;
  logic [31:0] q_f, q_r;
  logic        mreq_f, mwe_f, mack_f, mreq_r, mwe_r, mack_r;
  logic [26:0] maddr_f, maddr_r, wba_f, wba_r;
  logic [255:0] mwd_f, mrd_f, mwd_r, mrd_r, wbd_f, wbd_r;
  int          wbc_f, wbc_r;

  int total = 0;
  int bad = 0;

  fa_cache #(.REPL(REPL_FIFO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_f), .we_i(we_f), .addr_i(addr_f), .wdata_i(wd_f),
    .ready_o(rdy_f), .resp_valid_o(rv_f), .hit_o(hit_f), .line_o(line_f), .rdata_o(q_f),
    .mem_req_o(mreq_f), .mem_we_o(mwe_f), .mem_addr_o(maddr_f), .mem_wdata_o(mwd_f),
    .mem_ack_i(mack_f), .mem_rdata_i(mrd_f));

  fa_cache #(.REPL(REPL_RANDOM), .LFSR_SEED(16'hACE1)) dut_r (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_r), .we_i(we_r), .addr_i(addr_r), .wdata_i(wd_r),
    .ready_o(rdy_r), .resp_valid_o(rv_r), .hit_o(hit_r), .line_o(line_r), .rdata_o(q_r),
    .mem_req_o(mreq_r), .mem_we_o(mwe_r), .mem_addr_o(maddr_r), .mem_wdata_o(mwd_r),
    .mem_ack_i(mack_r), .mem_rdata_i(mrd_r));

  tb_mem u_mem_f (.clk(clk), .rst_n(rst_n), .req(mreq_f), .we(mwe_f), .addr(maddr_f), .wdata(mwd_f),
    .ack(mack_f), .rdata(mrd_f), .wb_cnt(wbc_f), .wb_addr(wba_f), .wb_data(wbd_f));
  tb_mem u_mem_r (.clk(clk), .rst_n(rst_n), .req(mreq_r), .we(mwe_r), .addr(maddr_r), .wdata(mwd_r),
    .ack(mack_r), .rdata(mrd_r), .wb_cnt(wbc_r), .wb_addr(wba_r), .wb_data(wbd_r));

  function automatic logic [31:0] pat(input logic [26:0] b, input int w);
    return (32'(b) * 8 + 32'(w)) * 32'h9E3779B1 + 32'h1234;
  endfunction

  function automatic logic [31:0] mk(input logic [26:0] b, input int w);
    return {b, 3'(w), 2'b00};
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic acc(input bit rnd, input bit we, input logic [31:0] a, input logic [31:0] d,
                     output logic h, output logic [2:0] ln, output logic [31:0] q,
                     output int lat, output int busy_rdy);
    @(negedge clk);
    while (!(rnd ? rdy_r : rdy_f)) @(negedge clk);
    if (rnd) begin req_r = 1; we_r = we; addr_r = a; wd_r = d; end
    else     begin req_f = 1; we_f = we; addr_f = a; wd_f = d; end
    @(negedge clk);
    req_r = 0; req_f = 0;
    lat = 1; busy_rdy = 0;
    while (!(rnd ? rv_r : rv_f)) begin
      if (rnd ? rdy_r : rdy_f) busy_rdy++;
      @(negedge clk);
      lat++;
    end
    h = rnd ? hit_r : hit_f; ln = rnd ? line_r : line_f; q = rnd ? q_r : q_f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic h; logic [2:0] ln; logic [31:0] q; int lat, br;
    logic [15:0] lf;
    logic [31:0] xval, yval;
    xval = 32'hDEADBEEF;
    yval = 32'h0BADF00D;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdy_f && !rv_f && !mreq_f, "R1 reset fifo", {rdy_f, rv_f, mreq_f}, 3'b100);
    chk(rdy_r && !rv_r && !mreq_r, "R1 reset rnd", {rdy_r, rv_r, mreq_r}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_f && !rv_f && !mreq_f, "R1 after release", {rdy_f, rv_f, mreq_f}, 3'b100);

    // R6/R5 cold fill, lowest invalid line first
    for (int i = 0; i < 8; i++) begin
      acc(0, 0, mk(27'h100 + 27'(i), i), 0, h, ln, q, lat, br);
      chk(!h && ln == 3'(i), "R6 cold fill line", {h, ln}, {1'b0, 3'(i)});
      chk(q == pat(27'h100 + 27'(i), i), "R5 miss data", q, pat(27'h100 + 27'(i), i));
      chk(br == 0 && lat > 1, "R10 busy during miss", br, 0);
    end
    chk(wbc_f == 0, "R7 no writeback on cold fill", wbc_f, 0);

    // R3/R2 every word of every block hits
    for (int i = 0; i < 8; i++) begin
      for (int w = 0; w < 8; w++) begin
        acc(0, 0, mk(27'h100 + 27'(i), w), 0, h, ln, q, lat, br);
        chk(h && ln == 3'(i) && lat == 1, "R3 hit line/latency", {h, ln, lat[7:0]}, {1'b1, 3'(i), 8'd1});
        chk(q == pat(27'h100 + 27'(i), w), "R3 hit word", q, pat(27'h100 + 27'(i), w));
      end
    end
    // R2 byte offset bits ignored
    acc(0, 0, mk(27'h105, 6) | 32'h3, 0, h, ln, q, lat, br);
    chk(h && q == pat(27'h105, 6), "R2 byte offset ignored", q, pat(27'h105, 6));

    // R4 write hit
    acc(0, 1, mk(27'h102, 5), xval, h, ln, q, lat, br);
    chk(h && ln == 3'd2 && q == xval, "R4 write hit", {h, ln, q}, {1'b1, 3'd2, xval});
    acc(0, 0, mk(27'h102, 5), 0, h, ln, q, lat, br);
    chk(h && q == xval, "R4 read after write", q, xval);
    acc(0, 0, mk(27'h102, 4), 0, h, ln, q, lat, br);
    chk(q == pat(27'h102, 4), "R4 neighbour word intact", q, pat(27'h102, 4));
    chk(wbc_f == 0 && !mreq_f, "R3 hits make no memory traffic", wbc_f, 0);

    // R8 FIFO order ignores hits; R7 clean victims not written
    acc(0, 0, mk(27'h200, 0), 0, h, ln, q, lat, br);
    chk(!h && ln == 3'd0, "R8 oldest fill evicted", {h, ln}, 4'd0);
    chk(wbc_f == 0, "R7 clean victim no write", wbc_f, 0);
    acc(0, 0, mk(27'h201, 0), 0, h, ln, q, lat, br);
    chk(ln == 3'd1, "R8 next oldest", ln, 1);
    acc(0, 0, mk(27'h202, 1), 0, h, ln, q, lat, br);
    chk(ln == 3'd2 && q == pat(27'h202, 1), "R8 dirty line evicted", {ln, q}, {3'd2, pat(27'h202, 1)});
    chk(wbc_f == 1 && wba_f == 27'h102, "R7 writeback address", {wbc_f[7:0], wba_f}, {8'd1, 27'h102});
    chk(wbd_f[5*32 +: 32] == xval && wbd_f[0 +: 32] == pat(27'h102, 0), "R7 writeback line",
        wbd_f[5*32 +: 32], xval);
    acc(0, 0, mk(27'h102, 5), 0, h, ln, q, lat, br);
    chk(!h && ln == 3'd3 && q == xval, "R7 refetch sees written word", {h, ln, q}, {1'b0, 3'd3, xval});

    // R5 write miss merge
    acc(0, 1, mk(27'h300, 2), yval, h, ln, q, lat, br);
    chk(!h && ln == 3'd4 && q == yval, "R5 write miss", {h, ln, q}, {1'b0, 3'd4, yval});
    acc(0, 0, mk(27'h300, 2), 0, h, ln, q, lat, br);
    chk(h && q == yval, "R5 merged word", q, yval);
    acc(0, 0, mk(27'h300, 3), 0, h, ln, q, lat, br);
    chk(h && q == pat(27'h300, 3), "R5 merged line rest", q, pat(27'h300, 3));

    // R8 wrap of FIFO order, R7 dirty write-miss line written back
    for (int k = 1; k <= 8; k++) begin
      acc(0, 0, mk(27'h300 + 27'(k), 0), 0, h, ln, q, lat, br);
      chk(!h && ln == 3'((4 + k) % 8), "R8 fifo wrap", ln, (4 + k) % 8);
    end
    chk(wbc_f == 2 && wba_f == 27'h300 && wbd_f[2*32 +: 32] == yval, "R7 dirty fill written back",
        {wbc_f[7:0], wba_f}, {8'd2, 27'h300});

    // R9 random policy on second instance
    for (int i = 0; i < 8; i++) begin
      acc(1, 0, mk(27'h400 + 27'(i), 0), 0, h, ln, q, lat, br);
      chk(!h && ln == 3'(i), "R6 rnd cold fill", ln, i);
    end
    lf = 16'hACE1;
    for (int k = 0; k < 12; k++) begin
      acc(1, 0, mk(27'h500 + 27'(k), 7), 0, h, ln, q, lat, br);
      chk(!h && ln == lf[2:0], "R9 lfsr victim", ln, lf[2:0]);
      chk(q == pat(27'h500 + 27'(k), 7), "R9 data", q, pat(27'h500 + 27'(k), 7));
      lf = lfsr_next(lf);
      acc(1, 0, mk(27'h500 + 27'(k), 1), 0, h, ln, q, lat, br);
      chk(h, "R9 hit after fill", h, 1);
    end
    chk(wbc_r == 0, "R7 rnd clean victims", wbc_r, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule